// File: doc/BRIEF.md
# Codec Response Ring Writer

This block receives responses coming back from audio codecs and turns each one into a ring entry in system memory. A response arrives with its 32-bit payload, the 4-bit address of the codec that produced it, and a flag saying whether the codec sent it unprompted. The block writes two words per entry: the payload first, then a tag word that carries the codec address and the unsolicited flag. The entries go into a circular ring of 2^IDX_W slots, and a write pointer tracks the most recently filled slot.

Software controls the block through a small write port. It can enable ring writing, enable the response interrupt status, set the entry-count threshold, set the ring base address, reset the write pointer, and acknowledge the status bit. When software has issued an immediate command, the next response bypasses the ring and lands in a single immediate-response register. When the status bit is acknowledged, the block pulses `fetch_resume` so that the command fetcher can look at its ring again.

The block is controlled by a three-state machine. `ST_IDLE` accepts a response. The transition *capture* or *drop* keeps it in `ST_IDLE`, while *start* moves it to `ST_WR_RESP`. In `ST_WR_RESP` the payload word is offered to memory. The transition *resp_accepted* moves to `ST_WR_EXT`, where the tag word is offered. The transition *ext_accepted* returns to `ST_IDLE` and commits the entry.

Top module: `rsp_ring_writer`

## Requirements
- R1: While the immediate-busy flag (`imm_status` bit 0) is set, an accepted response goes to `imm_resp` and is not written to the ring. The busy flag clears, the valid flag (bit 1) sets, and the codec address goes to bits 7:4. Writing select 5 with data bit 0 set raises busy. Writing select 5 with data bit 1 set clears valid.
- R2: When ring writing is disabled (select 0, data bit 0 clear) and no immediate command is busy, a response is accepted and dropped. No memory write is issued and `wr_ptr` is unchanged.
- R3: An entry goes to slot n = (`wr_ptr` + 1) mod 2^IDX_W. The payload is written at base + 8·n and the tag word at base + 8·n + 4. The base is programmed through select 4, and its low 3 bits are forced to zero.
- R4: The tag word has the codec address in bits 3:0, bit 4 set for an unsolicited response, and all other bits zero.
- R5: Each committed entry increments a response counter. When the counter reaches the threshold (select 1, low IDX_W bits), `irq_status` sets, provided the interrupt enable (select 0, data bit 1) is set.
- R6: If `cmd_ring_empty` is high in the cycle an entry commits and the interrupt enable is set, `irq_status` sets regardless of the counter.
- R7: With the interrupt enable clear, committed entries never set `irq_status`.
- R8: Writing select 3 with data bit 0 set while `irq_status` is set clears the status and resets the counter to zero. It also pulses `fetch_resume` high for exactly one cycle.
- R9: Writing select 2 with data bit 15 set clears `wr_ptr` to zero.
- R10: The two words of an entry are offered back to back. Address and data are held while `mem_wr_ready` is low, and `wr_ptr` advances only once the tag word is accepted.
- R11: The slot index wraps: from `wr_ptr` = 2^IDX_W − 1 the next entry goes to slot 0.
- R12: `rsp_ready` is high in `ST_IDLE` and low while an entry is being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | Codec response present |
| rsp_ready | output | 1 | Block can accept a response |
| rsp_data | input | 32 | Response payload |
| rsp_unsol | input | 1 | Response is unsolicited |
| rsp_cad | input | 4 | Codec address of the responder |
| cmd_ring_empty | input | 1 | Command ring currently has no pending commands |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select: 0 control, 1 threshold, 2 pointer, 3 status, 4 base, 5 immediate |
| reg_wr_data | input | 32 | Register write data |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Byte address of the write |
| mem_wr_data | output | 32 | Write data |
| wr_ptr | output | IDX_W | Index of the last filled ring slot |
| irq_status | output | 1 | Response interrupt status |
| fetch_resume | output | 1 | One-cycle pulse after status acknowledge |
| imm_resp | output | 32 | Immediate response payload |
| imm_status | output | 8 | {codec address, 2'b0, valid, busy} |

## Verification
The bench builds the block with IDX_W = 4, which gives a 16-slot ring, and with ADDR_W = 32. The small ring puts the index wrap from slot 15 to slot 0 within a 16-entry burst, and it limits the threshold to 4 bits so that a threshold of 3 is reached after a handful of responses. The memory-ready input is driven by the bench, so stalls can be held on the payload word and again between the two words of an entry.

// File: rtl/hda_rsp_pkg.sv
package hda_rsp_pkg;

    localparam int DATA_W = 32;
    localparam int CAD_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_RESP = 2'd1,
        ST_WR_EXT  = 2'd2
    } wr_state_e;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_THRESH = 3'd1,
        SEL_WPTR   = 3'd2,
        SEL_STATUS = 3'd3,
        SEL_BASE   = 3'd4,
        SEL_IMM    = 3'd5
    } reg_sel_e;

    localparam int CTRL_DMA_BIT  = 0;
    localparam int CTRL_IRQ_BIT  = 1;
    localparam int WPTR_RST_BIT  = 15;
    localparam int STS_IRQ_BIT   = 0;
    localparam int IMM_BUSY_BIT  = 0;
    localparam int IMM_VALID_BIT = 1;
    localparam int EXT_UNSOL_BIT = 4;

endpackage

// File: rtl/rsp_ring_fsm.sv
module rsp_ring_fsm
    import hda_rsp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              rsp_unsol,
    input  logic [CAD_W-1:0]  rsp_cad,
    input  logic              imm_busy,
    input  logic              dma_en,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [IDX_W-1:0]  wp,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              imm_capture,
    output logic              entry_done,
    output logic [IDX_W-1:0]  wp_next
);
    localparam int ENTRY_SHIFT = 3;
    localparam int EXT_OFFSET  = 4;
    localparam int PAD_W       = DATA_W - CAD_W - 1;

    wr_state_e          state, state_nx;
    logic [DATA_W-1:0]  lat_data;
    logic [DATA_W-1:0]  lat_ext;
    logic [IDX_W-1:0]   lat_idx;
    logic [ADDR_W-1:0]  entry_addr;
    logic               fire;
    logic               start;

    assign fire  = rsp_valid && rsp_ready;
    assign start = fire && !imm_busy && dma_en;
    assign entry_addr = ring_base + (ADDR_W'(lat_idx) << ENTRY_SHIFT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start)        state_nx = ST_WR_RESP;
            ST_WR_RESP: if (mem_wr_ready) state_nx = ST_WR_EXT;
            ST_WR_EXT:  if (mem_wr_ready) state_nx = ST_IDLE;
            default:                      state_nx = ST_IDLE;
        endcase
    end

    // entry latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_data <= '0;
            lat_ext  <= '0;
            lat_idx  <= '0;
        end else if (start) begin
            lat_data <= rsp_data;
            lat_ext  <= {{PAD_W{1'b0}}, rsp_unsol, rsp_cad};
            lat_idx  <= wp + 1'b1;
        end
    end

    // outputs
    always_comb begin
        rsp_ready    = 1'b0;
        mem_wr_valid = 1'b0;
        mem_wr_addr  = entry_addr;
        mem_wr_data  = lat_data;
        entry_done   = 1'b0;
        unique case (state)
            ST_IDLE: rsp_ready = 1'b1;
            ST_WR_RESP: mem_wr_valid = 1'b1;
            ST_WR_EXT: begin
                mem_wr_valid = 1'b1;
                mem_wr_addr  = entry_addr + ADDR_W'(EXT_OFFSET);
                mem_wr_data  = lat_ext;
                entry_done   = mem_wr_ready;
            end
            default: rsp_ready = 1'b0;
        endcase
    end

    assign imm_capture = fire && imm_busy;
    assign wp_next     = lat_idx;

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R10
    AST_EXT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_RESP && mem_wr_ready) |=> (mem_wr_valid && mem_wr_addr == $past(mem_wr_addr) + ADDR_W'(EXT_OFFSET))); // R10
    AST_IMM_NO_RING: assert property (@(posedge clk) disable iff (!rst_n)
        imm_capture |=> !mem_wr_valid); // R1
    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !dma_en && !imm_busy) |=> !mem_wr_valid); // R2
endmodule

// File: rtl/rsp_ring_ctl.sv
module rsp_ring_ctl
    import hda_rsp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_sel,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic              entry_done,
    input  logic [IDX_W-1:0]  wp_next,
    output logic              dma_en,
    output logic              irq_en,
    output logic [IDX_W-1:0]  thresh,
    output logic [ADDR_W-1:0] ring_base,
    output logic [IDX_W-1:0]  wp,
    output logic              sts_clr,
    output logic              imm_set,
    output logic              imm_vclr
);
    localparam int ALIGN_W = 3;

    reg_sel_e sel;
    logic     wp_rst;
    logic     unused_bits;

    assign sel      = reg_sel_e'(reg_wr_sel);
    assign wp_rst   = reg_wr_en && sel == SEL_WPTR && reg_wr_data[WPTR_RST_BIT];
    assign sts_clr  = reg_wr_en && sel == SEL_STATUS && reg_wr_data[STS_IRQ_BIT];
    assign imm_set  = reg_wr_en && sel == SEL_IMM && reg_wr_data[IMM_BUSY_BIT];
    assign imm_vclr = reg_wr_en && sel == SEL_IMM && reg_wr_data[IMM_VALID_BIT];
    assign unused_bits = ^reg_wr_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_en    <= 1'b0;
            irq_en    <= 1'b0;
            thresh    <= '0;
            ring_base <= '0;
        end else if (reg_wr_en) begin
            unique case (sel)
                SEL_CTRL: begin
                    dma_en <= reg_wr_data[CTRL_DMA_BIT];
                    irq_en <= reg_wr_data[CTRL_IRQ_BIT];
                end
                SEL_THRESH: thresh    <= reg_wr_data[IDX_W-1:0];
                SEL_BASE:   ring_base <= {reg_wr_data[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          wp <= '0;
        else if (entry_done) wp <= wp_next;
        else if (wp_rst)     wp <= '0;
    end

    AST_WP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wp != $past(wp)) |-> (wp == IDX_W'($past(wp) + 1'b1) || wp == '0)); // R3
    AST_WP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_rst && !entry_done) |=> (wp == '0)); // R9
endmodule

// File: rtl/rsp_ring_irq.sv
module rsp_ring_irq #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_done,
    input  logic             cmd_ring_empty,
    input  logic             irq_en,
    input  logic [IDX_W-1:0] thresh,
    input  logic             sts_clr,
    output logic             irq_status,
    output logic             fetch_resume
);
    logic [IDX_W-1:0] count;
    logic [IDX_W-1:0] count_base;
    logic [IDX_W-1:0] count_inc;
    logic             clr_hit;
    logic             raise;

    assign clr_hit    = sts_clr && irq_status;
    assign count_base = clr_hit ? '0 : count;
    assign count_inc  = count_base + 1'b1;
    assign raise      = entry_done && irq_en && (count_inc == thresh || cmd_ring_empty);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count        <= '0;
            irq_status   <= 1'b0;
            fetch_resume <= 1'b0;
        end else begin
            count        <= entry_done ? count_inc : count_base;
            fetch_resume <= clr_hit;
            if (raise)        irq_status <= 1'b1;
            else if (clr_hit) irq_status <= 1'b0;
        end
    end

    AST_STS_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_status) |-> $past(sts_clr)); // R8
    AST_STS_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status) |-> ($past(irq_en) && $past(entry_done))); // R7
    AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_resume |=> !fetch_resume); // R8
endmodule

// File: rtl/rsp_imm_slot.sv
module rsp_imm_slot
    import hda_rsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              imm_set,
    input  logic              imm_vclr,
    input  logic              imm_capture,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [CAD_W-1:0]  rsp_cad,
    output logic              imm_busy,
    output logic [DATA_W-1:0] imm_resp,
    output logic [7:0]        imm_status
);
    logic             valid;
    logic [CAD_W-1:0] cad;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imm_busy <= 1'b0;
            valid    <= 1'b0;
            cad      <= '0;
            imm_resp <= '0;
        end else if (imm_capture) begin
            imm_busy <= 1'b0;
            valid    <= 1'b1;
            cad      <= rsp_cad;
            imm_resp <= rsp_data;
        end else begin
            if (imm_set)  imm_busy <= 1'b1;
            if (imm_vclr) valid    <= 1'b0;
        end
    end

    assign imm_status = {cad, 2'b00, valid, imm_busy};

    AST_IMM_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(imm_capture)); // R1
endmodule

// File: rtl/rsp_ring_writer.sv
module rsp_ring_writer
    import hda_rsp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [31:0]       rsp_data,
    input  logic              rsp_unsol,
    input  logic [3:0]        rsp_cad,
    input  logic              cmd_ring_empty,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_sel,
    input  logic [31:0]       reg_wr_data,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic [IDX_W-1:0]  wr_ptr,
    output logic              irq_status,
    output logic              fetch_resume,
    output logic [31:0]       imm_resp,
    output logic [7:0]        imm_status
);
    logic              dma_en, irq_en, sts_clr, imm_set, imm_vclr;
    logic              imm_busy, imm_capture, entry_done;
    logic [IDX_W-1:0]  thresh, wp_next;
    logic [ADDR_W-1:0] ring_base;

    rsp_ring_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) ctl_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .entry_done(entry_done), .wp_next(wp_next),
        .dma_en(dma_en), .irq_en(irq_en), .thresh(thresh), .ring_base(ring_base),
        .wp(wr_ptr), .sts_clr(sts_clr), .imm_set(imm_set), .imm_vclr(imm_vclr)
    );

    rsp_ring_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_unsol(rsp_unsol), .rsp_cad(rsp_cad),
        .imm_busy(imm_busy), .dma_en(dma_en), .ring_base(ring_base), .wp(wr_ptr),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .imm_capture(imm_capture), .entry_done(entry_done), .wp_next(wp_next)
    );

    rsp_ring_irq #(.IDX_W(IDX_W)) irq_i (
        .clk(clk), .rst_n(rst_n),
        .entry_done(entry_done), .cmd_ring_empty(cmd_ring_empty),
        .irq_en(irq_en), .thresh(thresh), .sts_clr(sts_clr),
        .irq_status(irq_status), .fetch_resume(fetch_resume)
    );

    rsp_imm_slot imm_i (
        .clk(clk), .rst_n(rst_n),
        .imm_set(imm_set), .imm_vclr(imm_vclr), .imm_capture(imm_capture),
        .rsp_data(rsp_data), .rsp_cad(rsp_cad),
        .imm_busy(imm_busy), .imm_resp(imm_resp), .imm_status(imm_status)
    );

    AST_READY_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> !rsp_ready); // R12
endmodule

// File: tb/rsp_ring_writer_tb.sv
`timescale 1ns/1ps
module rsp_ring_writer_tb_top;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 4;
    localparam int SLOTS  = 1 << IDX_W;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rsp_valid = 1'b0, rsp_unsol = 1'b0, cmd_ring_empty = 1'b0;
    logic [31:0] rsp_data = '0;
    logic [3:0]  rsp_cad = '0;
    logic reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_sel = '0;
    logic [31:0] reg_wr_data = '0;
    logic mem_wr_ready = 1'b1;
    logic rsp_ready, mem_wr_valid, irq_status, fetch_resume;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [31:0] mem_wr_data, imm_resp;
    logic [IDX_W-1:0] wr_ptr;
    logic [7:0] imm_status;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    int exp_wp = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    rsp_ring_writer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_unsol(rsp_unsol), .rsp_cad(rsp_cad), .cmd_ring_empty(cmd_ring_empty),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .wr_ptr(wr_ptr), .irq_status(irq_status), .fetch_resume(fetch_resume),
        .imm_resp(imm_resp), .imm_status(imm_status)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected memory writes
    always @(negedge clk) begin
        #1;
        if (rst_n && mem_wr_valid && mem_wr_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected memory write", {mem_wr_addr, mem_wr_data}, 64'h0);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({mem_wr_addr, mem_wr_data} == e, t, {mem_wr_addr, mem_wr_data}, e);
            end
        end
    end

    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] data);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // driver: pushes expected ring words, presents the response
    task automatic send_rsp(input logic [31:0] data, input bit unsol, input logic [3:0] cad, input bit to_ring);
        while (!rsp_ready) @(negedge clk);
        if (to_ring) begin
            int nxt;
            nxt = (exp_wp + 1) % SLOTS;
            exp_q.push_back({BASE + 32'(nxt * 8), data});
            tag_q.push_back("R3 payload word");
            exp_q.push_back({BASE + 32'(nxt * 8 + 4), 27'b0, unsol, cad});
            tag_q.push_back("R4 tag word");
            exp_wp = nxt;
        end
        rsp_valid = 1'b1; rsp_data = data; rsp_unsol = unsol; rsp_cad = cad;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!rsp_ready) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'h0, 64'h1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(rsp_ready == 1'b1, "R12 ready after reset", rsp_ready, 1);
        chk(mem_wr_valid == 1'b0, "R10 no write after reset", mem_wr_valid, 0);
        chk(wr_ptr == 0 && irq_status == 0 && imm_status == 0, "R9 reset state",
            {wr_ptr, irq_status, imm_status}, 0);

        wr_reg(3'd4, BASE);
        wr_reg(3'd1, 32'd3);
        wr_reg(3'd0, 32'h3);

        // three entries, threshold 3
        send_rsp(32'hA5A5_0001, 1'b0, 4'h2, 1'b1); wait_idle();
        chk(wr_ptr == 1, "R3 wp after first entry", wr_ptr, 1);
        chk(irq_status == 0, "R5 below threshold", irq_status, 0);
        send_rsp(32'h1234_5678, 1'b1, 4'h5, 1'b1); wait_idle();
        chk(irq_status == 0, "R5 below threshold 2", irq_status, 0);
        send_rsp(32'hDEAD_BEEF, 1'b0, 4'hF, 1'b1); wait_idle();
        chk(irq_status == 1, "R5 threshold reached", irq_status, 1);
        chk(wr_ptr == 3, "R3 wp after three", wr_ptr, 3);

        // acknowledge
        wr_reg(3'd3, 32'h1);
        chk(irq_status == 0, "R8 status cleared", irq_status, 0);
        chk(fetch_resume == 1, "R8 resume pulse", fetch_resume, 1);
        @(negedge clk);
        chk(fetch_resume == 0, "R8 resume one cycle", fetch_resume, 0);

        // counter rearmed
        send_rsp(32'h0000_0011, 1'b0, 4'h1, 1'b1); wait_idle();
        send_rsp(32'h0000_0022, 1'b0, 4'h1, 1'b1); wait_idle();
        chk(irq_status == 0, "R8 counter rearmed", irq_status, 0);
        send_rsp(32'h0000_0033, 1'b0, 4'h1, 1'b1); wait_idle();
        chk(irq_status == 1, "R8 threshold after rearm", irq_status, 1);
        wr_reg(3'd3, 32'h1);

        // command ring empty
        cmd_ring_empty = 1'b1;
        send_rsp(32'h0000_0044, 1'b1, 4'h3, 1'b1); wait_idle();
        chk(irq_status == 1, "R6 ring empty raises status", irq_status, 1);
        wr_reg(3'd3, 32'h1);

        // interrupt disabled
        wr_reg(3'd0, 32'h1);
        send_rsp(32'h0000_0055, 1'b0, 4'h3, 1'b1); wait_idle();
        chk(irq_status == 0, "R7 no status when disabled", irq_status, 0);
        cmd_ring_empty = 1'b0;

        // ring disabled: drop
        wr_reg(3'd0, 32'h0);
        send_rsp(32'h0000_0066, 1'b0, 4'h4, 1'b0);
        @(negedge clk); @(negedge clk);
        chk(wr_ptr == IDX_W'(exp_wp), "R2 wp unchanged on drop", wr_ptr, exp_wp);
        chk(rsp_ready == 1, "R2 drop keeps idle", rsp_ready, 1);

        // immediate path
        wr_reg(3'd0, 32'h1);
        wr_reg(3'd5, 32'h1);
        chk(imm_status[0] == 1, "R1 busy set", imm_status, 1);
        send_rsp(32'hCAFE_F00D, 1'b0, 4'h9, 1'b0);
        chk(imm_resp == 32'hCAFE_F00D, "R1 immediate payload", imm_resp, 32'hCAFE_F00D);
        chk(imm_status == 8'h92, "R1 immediate status", imm_status, 8'h92);
        @(negedge clk);
        chk(wr_ptr == IDX_W'(exp_wp), "R1 ring untouched", wr_ptr, exp_wp);
        wr_reg(3'd5, 32'h2);
        chk(imm_status[1] == 0, "R1 valid cleared", imm_status, 8'h90);

        // stalled memory
        mem_wr_ready = 1'b0;
        send_rsp(32'h7777_0001, 1'b1, 4'hA, 1'b1);
        repeat (3) begin
            chk(mem_wr_valid == 1 && rsp_ready == 0, "R12 busy while stalled",
                {mem_wr_valid, rsp_ready}, 2'b10);
            chk(wr_ptr == IDX_W'(exp_wp - 1), "R10 wp held during stall", wr_ptr, exp_wp - 1);
            @(negedge clk);
        end
        mem_wr_ready = 1'b1;
        @(negedge clk);
        mem_wr_ready = 1'b0;
        chk(wr_ptr == IDX_W'(exp_wp - 1), "R10 wp held between words", wr_ptr, exp_wp - 1);
        @(negedge clk);
        mem_wr_ready = 1'b1;
        wait_idle();
        chk(wr_ptr == IDX_W'(exp_wp), "R10 wp after tag word", wr_ptr, exp_wp);

        // pointer reset and wrap
        wr_reg(3'd2, 32'h8000);
        exp_wp = 0;
        chk(wr_ptr == 0, "R9 pointer reset", wr_ptr, 0);
        for (int i = 0; i < SLOTS; i++) begin
            send_rsp(32'hB000_0000 + 32'(i), i[0], 4'(i), 1'b1); wait_idle();
        end
        chk(wr_ptr == 0, "R11 wrapped to slot 0", wr_ptr, 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all expected writes seen", exp_q.size(), 0);
        finish_run();
    end
endmodule